// File: doc/BRIEF.md
# Banked GPIO Pin Control Register File

This block is the register side of a general-purpose I/O port whose pin count is a multiple of 32. Software reaches it over a plain 32-bit register bus and uses it to sample pin levels, choose per-pin direction, raise and lower output latches through separate one-hot strobes, and pick one of four pad functions per pin. Each feature owns one 32-bit word per group of 32 pins. The alternate-function selector is the exception: it spends two bits per pin and so owns two words per group.

The address map is laid out feature by feature. All words of one feature sit together, and the next feature follows. Feature indices 4 to 6 are kept free for a separate edge-detect block. This block answers them with zero and ignores writes to them. Pin inputs are synchronized here, and the synchronized vector is handed to that neighbour.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: With NW = NUM_PINS/32, word b of feature f sits at byte address (f*NW + b)*4. Feature indices are 0 level, 1 direction, 2 set, 3 clear, 4 to 6 reserved for the edge block, and 7 alternate function. Pin p is bit p mod 32 of word p/32. Address bits [1:0] are ignored.
- R2: Each pin input passes through two flops before it reaches `pin_sync` and the level word. A change that is driven before clock edge k appears after edge k+1. Writes to the level word are ignored.
- R3: A direction bit of 1 makes the pin an output and 0 makes it an input. `pin_oe` equals the direction register. The direction word reads back what was written.
- R4: Writing the set word drives high the output latch of every pin whose data bit is 1. Pins whose data bit is 0 keep their latch value.
- R5: Writing the clear word drives low the output latch of every pin whose data bit is 1. Pins whose data bit is 0 keep their latch value.
- R6: A read of a set or clear word returns zero.
- R7: The alternate-function code of pin p is two bits at position (p mod 16)*2 in word 7*NW + p/16. It is presented on `af_sel[2p+1:2p]`, where 0 means plain GPIO, and it reads back as written.
- R8: After reset all pins are inputs, all output latches are 0, all alternate-function codes are 0 and `bus_rdata` is 0.
- R9: A word at or beyond 9*NW reads zero and has no write effect. So does any word of features 4 to 6.
- R10: `bus_rdata` is loaded at the clock edge where `bus_rd` is high. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| pin_in | input | NUM_PINS | Raw pad input levels |
| pin_out | output | NUM_PINS | Output latch values |
| pin_oe | output | NUM_PINS | Output enables (direction) |
| pin_sync | output | NUM_PINS | Synchronized inputs for the edge block |
| af_sel | output | 2*NUM_PINS | Alternate-function code per pin |

## Verification
The bench runs with 96 pins, which gives three words per feature. A decoder that assumes a power-of-two bank count would then land direction writes in the wrong bank or alias the alternate-function words. The bench overlaps set and clear patterns so that both strobes are tested on zero bits. A design that rewrote the whole latch word would wipe pins that were set earlier. It checks the synchronizer latency one cycle too early and again on time, so a single-flop or three-flop path is caught. It writes all ones to the reserved edge words, to the level word and to the first address past the map, then reads the outputs back. A decoder with a loose upper bound would corrupt the alternate-function codes or the direction bits.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int IDX_W = 8;

  typedef enum logic [3:0] {
    FT_LEVEL = 4'd0,
    FT_DIR   = 4'd1,
    FT_SET   = 4'd2,
    FT_CLR   = 4'd3,
    FT_RISE  = 4'd4,
    FT_FALL  = 4'd5,
    FT_EDGE  = 4'd6,
    FT_ALT   = 4'd7,
    FT_NONE  = 4'd15
  } feat_e;

  typedef struct packed {
    feat_e            feat;
    logic [IDX_W-1:0] idx;
  } dec_t;

  // Word number -> feature and word index within the feature
  function automatic dec_t decode_word(input int unsigned word, input int unsigned nw);
    dec_t d;
    d.feat = FT_NONE;
    d.idx  = '0;
    if (word < 7 * nw) begin
      d.feat = feat_e'(4'(word / nw));
      d.idx  = IDX_W'(word % nw);
    end else if (word < 9 * nw) begin
      d.feat = FT_ALT;
      d.idx  = IDX_W'(word - 7 * nw);
    end
    return d;
  endfunction

  // Apply one-hot set and clear masks to a latch word
  function automatic logic [31:0] apply_w1(input logic [31:0] cur, input logic [31:0] set_m,
                                           input logic [31:0] clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_in;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NW     = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output feat_e             feat,
  output logic [IDX_W-1:0]  idx,
  output logic              hit
);
  dec_t d;

  always_comb begin
    d    = decode_word(32'(addr >> 2), NW);
    feat = d.feat;
    idx  = d.idx;
    hit  = (d.feat == FT_LEVEL) || (d.feat == FT_DIR) || (d.feat == FT_SET) ||
           (d.feat == FT_CLR) || (d.feat == FT_ALT);
  end
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
  import gpio_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_dir,
  input  logic        we_set,
  input  logic        we_clr,
  input  logic [31:0] wdata,
  output logic [31:0] dir_q,
  output logic [31:0] out_q
);
  logic [31:0] set_m, clr_m;

  assign set_m = we_set ? wdata : '0;
  assign clr_m = we_clr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (we_dir) dir_q <= wdata;
      out_q <= apply_w1(out_q, set_m, clr_m);
    end
  end

  // R4
  set_hits_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_set |=> ((out_q & $past(wdata)) == $past(wdata)));
  // R4
  set_spares_zeros_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_set |=> ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));
  // R5
  clr_hits_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_clr |=> ((out_q & $past(wdata)) == 32'd0));
  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_dir |=> $stable(dir_q));
endmodule

// File: rtl/gpio_af_word.sv
module gpio_af_word (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] af_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  af_q <= '0;
    else if (we) af_q <= wdata;
  end

  // R7
  af_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(af_q));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [31:0]           bus_wdata,
  input  logic                  bus_rd,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic [NUM_PINS-1:0]   pin_sync,
  output logic [2*NUM_PINS-1:0] af_sel
);
  localparam int NW  = NUM_PINS / 32;
  localparam int NAF = NUM_PINS / 16;

  feat_e            dec_feat;
  logic [IDX_W-1:0] dec_idx;
  logic             dec_hit;
  logic [31:0]      lvl_w [NW];
  logic [31:0]      dir_w [NW];
  logic [31:0]      af_w  [NAF];
  logic [31:0]      rd_word;

  gpio_in_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pin_in), .d_sync(pin_sync)
  );

  gpio_addr_dec #(.ADDR_W(ADDR_W), .NW(NW)) u_dec (
    .addr(bus_addr), .feat(dec_feat), .idx(dec_idx), .hit(dec_hit)
  );

  for (genvar b = 0; b < NW; b++) begin : g_bank
    logic we_dir, we_set, we_clr;
    logic [31:0] out_w;
    assign we_dir = bus_wr && (dec_feat == FT_DIR) && (dec_idx == IDX_W'(b));
    assign we_set = bus_wr && (dec_feat == FT_SET) && (dec_idx == IDX_W'(b));
    assign we_clr = bus_wr && (dec_feat == FT_CLR) && (dec_idx == IDX_W'(b));
    gpio_pin_bank u_bank (
      .clk(clk), .rst_n(rst_n), .we_dir(we_dir), .we_set(we_set), .we_clr(we_clr),
      .wdata(bus_wdata), .dir_q(dir_w[b]), .out_q(out_w)
    );
    assign lvl_w[b]           = pin_sync[b*32 +: 32];
    assign pin_oe[b*32 +: 32]  = dir_w[b];
    assign pin_out[b*32 +: 32] = out_w;
  end

  for (genvar a = 0; a < NAF; a++) begin : g_af
    logic we_af;
    assign we_af = bus_wr && (dec_feat == FT_ALT) && (dec_idx == IDX_W'(a));
    gpio_af_word u_af (
      .clk(clk), .rst_n(rst_n), .we(we_af), .wdata(bus_wdata), .af_q(af_w[a])
    );
    assign af_sel[a*32 +: 32] = af_w[a];
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NAF; i++) begin
      if (dec_idx == IDX_W'(i)) begin
        if (dec_feat == FT_ALT) rd_word = af_w[i];
        if (i < NW && dec_feat == FT_LEVEL) rd_word = lvl_w[i % NW];
        if (i < NW && dec_feat == FT_DIR)   rd_word = dir_w[i % NW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  // R6
  strobe_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (dec_feat == FT_SET || dec_feat == FT_CLR)) |=> (bus_rdata == 32'd0));
  // R9
  hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !dec_hit) |=> (bus_rdata == 32'd0));
  // R9
  hole_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !dec_hit) |=> ($stable(pin_oe) && $stable(pin_out) && $stable(af_sel)));
  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
  localparam int NP = 96;
  localparam int NW = NP / 32;
  localparam int AW = 12;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 0, bus_rd = 0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, pin_sync;
  logic [2*NP-1:0] af_sel;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) u_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_sync(pin_sync), .af_sel(af_sel)
  );

  function automatic logic [AW-1:0] waddr(input int feat, input int word);
    return AW'((feat * NW + word) * 4);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R8 oe", 64'(pin_oe), 0);
    chk("R8 out", 64'(pin_out), 0);
    chk("R8 af", 64'(af_sel[63:0]), 0);
    chk("R8 rdata", 64'(bus_rdata), 0);
    rd(waddr(1, 2), d); chk("R8 dir word", 64'(d), 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    for (int b = 0; b < NW; b++) wr(waddr(1, b), 32'h5A00_0000 | 32'(b * 17 + 1));
    for (int b = 0; b < NW; b++) begin
      rd(waddr(1, b), d);
      chk("R1 dir readback", 64'(d), 64'(32'h5A00_0000 | 32'(b * 17 + 1)));
      chk("R3 oe slice", 64'(pin_oe[b*32 +: 32]), 64'(32'h5A00_0000 | 32'(b * 17 + 1)));
    end
    wr(waddr(1, 1) | AW'(3), 32'hFFFF_0000);
    chk("R1 low bits ignored", 64'(pin_oe[63:32]), 64'hFFFF_0000);
    wr(waddr(1, 1), 32'h0);
    chk("R3 dir cleared", 64'(pin_oe[63:32]), 0);
  endtask

  task automatic t_setclr();
    logic [31:0] d;
    wr(waddr(2, 1), 32'h0000_00F0);
    chk("R4 set", 64'(pin_out[63:32]), 64'h0000_00F0);
    wr(waddr(2, 1), 32'h0000_000F);
    chk("R4 zero bits kept", 64'(pin_out[63:32]), 64'h0000_00FF);
    wr(waddr(3, 1), 32'h0000_0030);
    chk("R5 clear", 64'(pin_out[63:32]), 64'h0000_00CF);
    chk("R4 other banks", 64'({pin_out[95:64], pin_out[31:0]}), 0);
    wr(waddr(2, 2), 32'h8000_0001);
    chk("R4 top bank", 64'(pin_out[95:64]), 64'h8000_0001);
    rd(waddr(2, 1), d); chk("R6 set reads zero", 64'(d), 0);
    rd(waddr(3, 2), d); chk("R6 clear reads zero", 64'(d), 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk); pin_in = {32'hCAFE_0001, 32'h1234_5678, 32'h0F0F_F0F0};
    @(negedge clk);
    chk("R2 not yet synced", 64'(pin_sync[31:0]), 0);
    @(negedge clk);
    chk("R2 synced", 64'(pin_sync[31:0]), 64'h0F0F_F0F0);
    rd(waddr(0, 1), d); chk("R2 level word", 64'(d), 64'h1234_5678);
    wr(waddr(0, 2), 32'hFFFF_FFFF);
    rd(waddr(0, 2), d); chk("R2 level write ignored", 64'(d), 64'hCAFE_0001);
    chk("R10 rdata holds", 64'(bus_rdata), 64'hCAFE_0001);
  endtask

  task automatic t_altfn();
    logic [31:0] d;
    wr(waddr(7, 1), 32'h0000_000C);
    chk("R7 pin17 code", 64'(af_sel[35:34]), 3);
    chk("R7 pin16 code", 64'(af_sel[33:32]), 0);
    wr(waddr(7, 2 * NW - 1), 32'h4000_0000);
    chk("R7 last pin code", 64'(af_sel[2*NP-1 -: 2]), 1);
    rd(waddr(7, 1), d); chk("R7 af readback", 64'(d), 64'h0000_000C);
  endtask

  task automatic t_holes();
    logic [31:0] d;
    logic [NP-1:0] oe0, out0;
    logic [2*NP-1:0] af0;
    oe0 = pin_oe; out0 = pin_out; af0 = af_sel;
    wr(waddr(4, 0), 32'hFFFF_FFFF);
    wr(waddr(6, 2), 32'hFFFF_FFFF);
    wr(waddr(9, 0), 32'hFFFF_FFFF);
    chk("R9 oe unchanged", 64'(pin_oe), 64'(oe0));
    chk("R9 out unchanged", 64'(pin_out), 64'(out0));
    chk("R9 af unchanged", af_sel[2*NP-1 -: 64], af0[2*NP-1 -: 64]);
    rd(waddr(5, 1), d); chk("R9 reserved reads zero", 64'(d), 0);
    rd(waddr(9, 0), d); chk("R9 beyond map reads zero", 64'(d), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_map();
    t_setclr();
    t_level();
    t_altfn();
    t_holes();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule